// File: doc/BRIEF.md
# Debounced 4x4 Matrix Keypad Scanner

This block scans a matrix keypad built from active-low column drive lines and active-low row sense lines. While the keypad is idle it pulls one column low per clock, in rotation. When a row line reads low, meaning a key joins that row to the driven column, the block stops rotating and holds the column that caused the detection. It then waits a fixed number of clock periods before it decides anything.

At the end of that wait the block samples the row detection a second time. If a row is still low, the block latches a key code and raises a valid flag. The flag stays high for as long as the key is held. If the row has gone high by then, the press is treated as noise and scanning resumes. The key code is the row index times the number of columns, plus the column index. With a 1 kHz scan clock, the default wait of ten periods gives a 10 ms qualification window.

The row lines pass through a synchronizer, so a detection always refers to the column that was driven a few clocks earlier. The scanner keeps a short history of the columns it has driven. At the instant of detection it returns to the column that produced the low row.

Top module: `keypad_scan_top`

## Requirements
- R1: While reset is asserted, and directly after it, column 0 is the driven column (column lines read 4'b1110), the valid flag is 0 and the key code is 0. Asserting reset at any time clears the valid flag and the key code at once.
- R2: While no key is pressed, exactly one column line is low, and the driven column advances by one on every clock in the order 0, 1, 2, 3, 0. Column line bit c belongs to column c.
- R3: Row inputs pass through two register stages before detection. When several row lines are low together, the lowest-numbered row is the one encoded.
- R4: Once a row is detected, rotation stops, and the driven column becomes and stays the column whose drive produced the detection. It holds for the whole qualification interval and while the key is held.
- R5: The valid flag rises only after the qualification count (parameter, default 10 clocks) completes with a row still detected. Measured from the clock at which a single key is first closed, the valid flag is first seen high after between QUAL+3 and QUAL+6 rising edges.
- R6: If no row is detected when the count ends, the valid flag stays low and rotation resumes one column per clock.
- R7: The key code is row index times 4 plus column index: bits [3:2] carry the row and bits [1:0] carry the column. It is present in the same cycle the valid flag rises.
- R8: The valid flag and the key code stay steady while the key is held. After a release, the valid flag is still high after two rising edges and is low after the third.
- R9: Detection is sampled only at the end of the qualification count, and the count restarts from zero on every new detection. A short release inside the window that is followed by a new press before the window ends still gives an accepted key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| row_n_i | input | 4 | Row sense lines, active low |
| col_n_o | output | 4 | Column drive lines, active low, one low at a time |
| key_code_o | output | 4 | Latched key code, row*4 + column |
| key_valid_o | output | 1 | High while a qualified key is held |

## Verification
The bench models the keypad as a switch matrix that connects each column drive to its rows. It drives the keypad with single keys in every row and column, and with a two-row press, checking both the code and the column held after detection. A design that froze on the column current at detection time, instead of the column that caused it, would lose the row and never report the key. A design that encoded the highest row, or swapped row and column in the code, would show the wrong value in the two-key and corner-key vectors.

A short press must not produce a valid flag, and rotation must visibly resume afterwards. A press with a brief dropout inside the window must still be accepted, which catches a design that demands a continuous hold. Timing checks on the rising and falling edges of the valid flag catch an off-by-one in the qualification count or in the synchronizer depth. A reset during a held key catches a design whose reset is not asynchronous.

// File: rtl/kps_pkg.sv
package kps_pkg;

  typedef enum logic [1:0] {
    ST_SCAN = 2'd0,
    ST_QUAL = 2'd1,
    ST_HOLD = 2'd2
  } kps_state_e;

endpackage

// File: rtl/kps_row_front.sv
module kps_row_front #(
  parameter int NUM_ROWS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_W      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ROWS-1:0] row_n_i,
  output logic                zdet_o,
  output logic [ROW_W-1:0]    row_code_o
);

  logic [NUM_ROWS-1:0] stage_q [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '1;
          else        stage_q[0] <= row_n_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  logic [NUM_ROWS-1:0] rows_n;
  assign rows_n = stage_q[SYNC_STAGES-1];
  assign zdet_o = ~(&rows_n);

  // lowest-numbered low row wins: scan from the top, last hit overrides
  always_comb begin
    row_code_o = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (!rows_n[i]) row_code_o = ROW_W'(i);
    end
  end

endmodule

// File: rtl/kps_col_scanner.sv
module kps_col_scanner #(
  parameter int NUM_COLS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int COL_W      = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_en_i,
  input  logic                rewind_i,
  output logic [NUM_COLS-1:0] col_n_o,
  output logic [COL_W-1:0]    col_idx_o
);

  logic [COL_W-1:0] col_q, col_d;
  logic [COL_W-1:0] hist_q [SYNC_STAGES];

  always_comb begin
    col_d = col_q;
    if (rewind_i) begin
      col_d = hist_q[SYNC_STAGES-1];
    end else if (scan_en_i) begin
      col_d = (col_q == COL_W'(NUM_COLS - 1)) ? '0 : col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end

  // record of the columns driven over the last SYNC_STAGES cycles
  generate
    for (genvar h = 0; h < SYNC_STAGES; h++) begin : g_hist
      if (h == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) hist_q[0] <= '0;
          else        hist_q[0] <= col_q;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) hist_q[h] <= '0;
          else        hist_q[h] <= hist_q[h-1];
        end
      end
    end
  endgenerate

  assign col_n_o   = ~(NUM_COLS'(1) << col_q);
  assign col_idx_o = col_q;

endmodule

// File: rtl/kps_ctrl.sv
module kps_ctrl
  import kps_pkg::*;
#(
  parameter int QUAL_CYCLES = 10,
  localparam int CNT_W      = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zdet_i,
  output logic scan_en_o,
  output logic rewind_o,
  output logic load_o,
  output logic valid_o
);

  kps_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_last;

  assign cnt_last = (cnt_q == CNT_W'(QUAL_CYCLES - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_SCAN: begin
        if (zdet_i) begin
          state_d = ST_QUAL;
          cnt_d   = '0;
        end
      end
      ST_QUAL: begin
        if (cnt_last) begin
          state_d = zdet_i ? ST_HOLD : ST_SCAN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (!zdet_i) state_d = ST_SCAN;
      end
      default: state_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SCAN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign scan_en_o = (state_q == ST_SCAN) && !zdet_i;
  assign rewind_o  = (state_q == ST_SCAN) && zdet_i;
  assign load_o    = zdet_i && (((state_q == ST_QUAL) && cnt_last) ||
                                (state_q == ST_HOLD));
  assign valid_o   = (state_q == ST_HOLD);

endmodule

// File: rtl/kps_key_latch.sv
module kps_key_latch #(
  parameter int NUM_COLS = 4,
  parameter int ROW_W    = 2,
  parameter int COL_W    = 2,
  parameter int KEY_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_code_i,
  input  logic [COL_W-1:0] col_code_i,
  output logic [KEY_W-1:0] key_code_o
);

  logic [KEY_W-1:0] key_q, key_d;

  always_comb begin
    key_d = key_q;
    if (load_i) begin
      key_d = KEY_W'(row_code_i) * KEY_W'(NUM_COLS) + KEY_W'(col_code_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  assign key_code_o = key_q;

endmodule

// File: rtl/keypad_scan_top.sv
module keypad_scan_top #(
  parameter int NUM_ROWS    = 4,
  parameter int NUM_COLS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 10,
  localparam int ROW_W      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int COL_W      = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int KEY_W      = $clog2(NUM_ROWS * NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ROWS-1:0] row_n_i,
  output logic [NUM_COLS-1:0] col_n_o,
  output logic [KEY_W-1:0]    key_code_o,
  output logic                key_valid_o
);

  logic             zdet;
  logic [ROW_W-1:0] row_code;
  logic [COL_W-1:0] col_idx;
  logic             scan_en;
  logic             rewind;
  logic             load;

  kps_row_front #(
    .NUM_ROWS    (NUM_ROWS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_n_i    (row_n_i),
    .zdet_o     (zdet),
    .row_code_o (row_code)
  );

  kps_col_scanner #(
    .NUM_COLS    (NUM_COLS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cols (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en_i (scan_en),
    .rewind_i  (rewind),
    .col_n_o   (col_n_o),
    .col_idx_o (col_idx)
  );

  kps_ctrl #(
    .QUAL_CYCLES (QUAL_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .zdet_i    (zdet),
    .scan_en_o (scan_en),
    .rewind_o  (rewind),
    .load_o    (load),
    .valid_o   (key_valid_o)
  );

  kps_key_latch #(
    .NUM_COLS (NUM_COLS),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .KEY_W    (KEY_W)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .row_code_i (row_code),
    .col_code_i (col_idx),
    .key_code_o (key_code_o)
  );

endmodule

// File: rtl/kps_scan_chk.sv
module kps_scan_chk #(
  parameter int NUM_COLS = 4,
  parameter int COL_W    = 2,
  parameter int KEY_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_COLS-1:0] col_n,
  input logic [COL_W-1:0]    col_idx,
  input logic                scan_en,
  input logic                rewind,
  input logic                zdet,
  input logic                valid,
  input logic [KEY_W-1:0]    key_code
);

  // R2
  col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~col_n) == 1);

  // R2
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (int'(col_idx) == ((int'($past(col_idx)) + 1) % NUM_COLS)));

  // R4
  col_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !rewind) |=> $stable(col_idx));

  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(zdet));

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !zdet) |=> !valid);

  // R7
  code_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (int'(key_code) % NUM_COLS) == int'(col_idx));

endmodule

bind keypad_scan_top kps_scan_chk #(
  .NUM_COLS (NUM_COLS),
  .COL_W    (COL_W),
  .KEY_W    (KEY_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .col_n    (col_n_o),
  .col_idx  (col_idx),
  .scan_en  (scan_en),
  .rewind   (rewind),
  .zdet     (zdet),
  .valid    (key_valid_o),
  .key_code (key_code_o)
);

// File: tb/keypad_scan_top_test.sv
module keypad_scan_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int QUAL       = 10;
  localparam int NVEC       = 10;

  // {pressed key mask, expected key code}
  localparam logic [19:0] VECS [NVEC] = '{
    {16'h0001, 4'd0},  {16'h0020, 4'd5},  {16'h0400, 4'd10},
    {16'h8000, 4'd15}, {16'h0008, 4'd3},  {16'h1000, 4'd12},
    {16'h0040, 4'd6},  {16'h0200, 4'd9},  {16'h1010, 4'd4},
    {16'h4004, 4'd2}
  };

  logic       clk;
  logic       rst_n;
  logic [3:0] row_n;
  logic [3:0] col_n;
  logic [3:0] key_code;
  logic       key_valid;
  logic [15:0] pressed;

  int checks;
  int fails;

  keypad_scan_top uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_n_i     (row_n),
    .col_n_o     (col_n),
    .key_code_o  (key_code),
    .key_valid_o (key_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // switch matrix: a closed key connects its row to its column drive
  always_comb begin
    row_n = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (pressed[r*4+c] && !col_n[c]) row_n[r] = 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] next_col(input logic [3:0] c);
    return {c[2:0], c[3]};
  endfunction

  task automatic wait_valid(inout int n);
    while (!key_valid && n < QUAL + 14) begin
      tick(1);
      n++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    checks  = 0;
    fails   = 0;
    rst_n   = 1'b0;
    pressed = '0;
    tick(3);
    // R1 reset state
    check(col_n == 4'b1110, "R1 col", col_n, 4'b1110);
    check(key_valid == 1'b0, "R1 valid", key_valid, 0);
    check(key_code == 4'd0, "R1 code", key_code, 0);
    rst_n = 1'b1;

    // R2 rotation, one column per clock
    begin
      logic [3:0] exp_c;
      exp_c = 4'b1110;
      for (int i = 0; i < 6; i++) begin
        tick(1);
        exp_c = next_col(exp_c);
        check(col_n == exp_c, "R2 rotate", col_n, exp_c);
      end
    end

    // vector table: press, qualify, hold, release
    for (int v = 0; v < NVEC; v++) begin
      int n;
      logic [3:0] exp_k;
      exp_k   = VECS[v][3:0];
      pressed = VECS[v][19:4];
      n = 0;
      wait_valid(n);
      // R5 latency window
      check(n >= QUAL + 3 && n <= QUAL + 6, "R5 latency", n, QUAL + 3);
      // R7 code (R3 lowest row for two-row vectors)
      check(key_code == exp_k, (v >= 8) ? "R3 R7 code" : "R7 code", key_code, exp_k);
      // R4 held column
      check(col_n == ~(4'b0001 << exp_k[1:0]), "R4 column", col_n, ~(4'b0001 << exp_k[1:0]));
      for (int h = 0; h < 5; h++) begin
        tick(1);
        check(key_valid && key_code == exp_k, "R8 hold", {key_valid, key_code}, {1'b1, exp_k});
      end
      pressed = '0;
      tick(2);
      check(key_valid == 1'b1, "R8 release+2", key_valid, 1);
      tick(1);
      check(key_valid == 1'b0, "R8 release+3", key_valid, 0);
      tick(3);
    end

    // R6 short press: no valid, rotation resumes
    begin
      bit seen;
      logic [3:0] prev;
      seen    = 1'b0;
      pressed = 16'h0080;
      tick(4);
      pressed = '0;
      for (int i = 0; i < QUAL + 10; i++) begin
        tick(1);
        if (key_valid) seen = 1'b1;
      end
      check(!seen, "R6 no valid", seen, 0);
      prev = col_n;
      for (int i = 0; i < 4; i++) begin
        tick(1);
        check(col_n == next_col(prev), "R6 resume", col_n, next_col(prev));
        prev = col_n;
      end
    end

    // R9 dropout inside the window is still accepted
    begin
      int n;
      pressed = 16'h0200;
      tick(5);
      pressed = '0;
      tick(1);
      pressed = 16'h0200;
      n = 6;
      wait_valid(n);
      check(n >= QUAL + 3 && n <= QUAL + 6, "R9 latency", n, QUAL + 3);
      check(key_code == 4'd9, "R9 code", key_code, 9);
    end

    // R1 asynchronous reset while a key is held
    rst_n = 1'b0;
    #1;
    check(key_valid == 1'b0, "R1 async valid", key_valid, 0);
    check(key_code == 4'd0, "R1 async code", key_code, 0);
    check(col_n == 4'b1110, "R1 async col", col_n, 4'b1110);
    pressed = '0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check(col_n == 4'b1101, "R2 after reset", col_n, 4'b1101);

    summary();
    $finish;
  end

endmodule